// File: doc/BRIEF.md
# Glitch-Free Delay-Line Control Encoder

This block drives the control inputs of a chain of N NAND-based delay elements. It takes a binary delay code and produces two coupled control vectors. The first, `sel_s`, is a thermometer code. The second, `sel_t`, is a one-cold code whose zero sits one place above the code. Together they put every element of the line into one of three states: pass, turn or post-turn. A per-element state word is also brought out so that neighbouring logic, or a monitor, can see the line configuration directly.

A new code is never written straight to the line. A strobe first places the code in a shadow register. The code is moved to the control vectors only on the clock cycle in which a selected transition of the delayed signal is seen. The transition may be rising, falling or either one. This timing lets the control bits settle ahead of the signal edge that travels down the chain, so the elements that enter or leave turn state never see a half-applied code. Codes above N-2 are clamped, so the post-turn element at c+1 always exists.

Top module: `dl_ctrl_encoder`

## Requirements
- R1: `sel_s[i]` is 0 for every element i below the applied code c, and 1 for every i at or above c.
- R2: `sel_t` is one-cold. Its single 0 is at index c+1 and every other bit is 1. Bit 0 is therefore always 1.
- R3: `elem_state[2i+1:2i]` gives the state of element i. The value 2'b00 is pass (S=0, T=1), 2'b01 is turn (S=1, T=1) and 2'b10 is post-turn (S=1, T=0). The element at c is in turn state, the element at c+1 is in post-turn state, and every element above c+1 is in turn state.
- R4: A strobed code larger than N-2 is applied as N-2.
- R5: When `code_valid` is high at a clock edge, `code_in` is stored as the pending code. The outputs do not change until a qualifying transition of `line_in` arrives. Once a pending code has been applied it is no longer pending, so later transitions leave the outputs unchanged.
- R6: A transition is a difference between `line_in` and its value at the previous clock edge. `edge_mode` selects which transitions qualify: 0 selects rising only, 1 selects falling only, and 2 or 3 selects either direction.
- R7: A pending code reaches `sel_s` and `sel_t` at the same clock edge in which its qualifying transition is first seen.
- R8: If a strobe and a qualifying transition arrive in the same cycle, the code that was already pending is applied and the newly strobed code stays pending. If nothing was pending, the new code waits for the next qualifying transition.
- R9: Reset loads code 0 with nothing pending. `sel_s` is then all ones, and `sel_t` is all ones except bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | $clog2(N) | Binary delay code |
| code_valid | input | 1 | Strobe that stores `code_in` as the pending code |
| edge_mode | input | 2 | Qualifying transition: 0 rising, 1 falling, 2 or 3 either |
| line_in | input | 1 | Sampled delayed-line input signal |
| sel_s | output | N | Thermometer control vector |
| sel_t | output | N | One-cold control vector |
| elem_state | output | 2*N | Two-bit state of each element |

## Verification
The bench goes after the cases where a wrong design would change the line at an unsafe moment. A strobe that is followed by no transition must leave the vectors alone; a design that applies it at once would update the line in mid-period. A transition of the wrong direction must also be ignored, or the selected mode would be meaningless. A transition that arrives after a code has been consumed must not apply anything again. A strobe that coincides with a transition would, in a design that got it wrong, jump straight to the newest code or lose one of the two codes. Out-of-range codes check the clamp; without it the post-turn element would fall off the end of the chain and `sel_t` would have no zero.

// File: rtl/dl_pkg.sv
package dl_pkg;

    typedef enum logic [1:0] {
        ELEM_PASS = 2'b00,
        ELEM_TURN = 2'b01,
        ELEM_POST = 2'b10
    } elem_state_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_ANY  = 2'b10,
        EDGE_ANY2 = 2'b11
    } edge_mode_e;

    function automatic elem_state_e decode_elem(input logic s, input logic t);
        if (!s)
            return ELEM_PASS;
        else if (t)
            return ELEM_TURN;
        else
            return ELEM_POST;
    endfunction

endpackage

// File: rtl/dl_edge_qual.sv
module dl_edge_qual
    import dl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_in,
    input  logic [1:0] edge_mode,
    output logic       qual_edge
);
    logic       line_q;
    logic       rise;
    logic       fall;
    edge_mode_e mode;

    always_ff @(posedge clk) begin
        if (rst)
            line_q <= 1'b0;
        else
            line_q <= line_in;
    end

    assign mode = edge_mode_e'(edge_mode);
    assign rise = line_in & ~line_q;
    assign fall = ~line_in & line_q;

    always_comb begin
        unique case (mode)
            EDGE_RISE: qual_edge = rise;
            EDGE_FALL: qual_edge = fall;
            default:   qual_edge = rise | fall;
        endcase
    end
endmodule

// File: rtl/dl_code_shadow.sv
module dl_code_shadow #(
    parameter int N  = 8,
    parameter int CW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] code_in,
    input  logic          code_valid,
    input  logic          qual_edge,
    output logic          apply,
    output logic [CW-1:0] apply_code
);
    localparam int MAXC = N - 2;
    localparam logic [CW-1:0] MAXC_V = CW'(MAXC);

    logic [CW-1:0] shadow_q;
    logic          pend_q;
    logic [CW-1:0] clamped;

    assign clamped    = (code_in > MAXC_V) ? MAXC_V : code_in;
    assign apply      = qual_edge & pend_q;
    assign apply_code = shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (code_valid) begin
                shadow_q <= clamped;
                pend_q   <= 1'b1;
            end else if (apply) begin
                pend_q   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dl_vec_encoder.sv
module dl_vec_encoder
    import dl_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          apply,
    input  logic [CW-1:0] apply_code,
    output logic [N-1:0]  sel_s,
    output logic [N-1:0]  sel_t,
    output logic [2*N-1:0] elem_state
);
    logic [N-1:0] s_q;
    logic [N-1:0] t_q;
    int unsigned  code_u;

    assign code_u = int'(apply_code);

    for (genvar i = 0; i < N; i++) begin : g_elem
        localparam int unsigned IU = i;
        always_ff @(posedge clk) begin
            if (rst) begin
                s_q[i] <= 1'b1;
                t_q[i] <= (i != 1);
            end else if (apply) begin
                s_q[i] <= (IU >= code_u);
                t_q[i] <= (IU != code_u + 1);
            end
        end
        assign elem_state[2*i +: 2] = decode_elem(s_q[i], t_q[i]);
    end

    assign sel_s = s_q;
    assign sel_t = t_q;
endmodule

// File: rtl/dl_ctrl_encoder.sv
module dl_ctrl_encoder #(
    parameter int N  = 8,
    parameter int CW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [CW-1:0]  code_in,
    input  logic           code_valid,
    input  logic [1:0]     edge_mode,
    input  logic           line_in,
    output logic [N-1:0]   sel_s,
    output logic [N-1:0]   sel_t,
    output logic [2*N-1:0] elem_state
);
    logic          qual_edge;
    logic          apply;
    logic [CW-1:0] apply_code;

    dl_edge_qual u_edge (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .edge_mode (edge_mode),
        .qual_edge (qual_edge)
    );

    dl_code_shadow #(.N(N), .CW(CW)) u_shadow (
        .clk        (clk),
        .rst        (rst),
        .code_in    (code_in),
        .code_valid (code_valid),
        .qual_edge  (qual_edge),
        .apply      (apply),
        .apply_code (apply_code)
    );

    dl_vec_encoder #(.N(N), .CW(CW)) u_enc (
        .clk        (clk),
        .rst        (rst),
        .apply      (apply),
        .apply_code (apply_code),
        .sel_s      (sel_s),
        .sel_t      (sel_t),
        .elem_state (elem_state)
    );
endmodule

// File: rtl/dl_ctrl_encoder_chk.sv
module dl_ctrl_encoder_chk #(
    parameter int N  = 8,
    parameter int CW = $clog2(N)
) (
    input logic           clk,
    input logic           rst,
    input logic [CW-1:0]  code_in,
    input logic           code_valid,
    input logic [1:0]     edge_mode,
    input logic           line_in,
    input logic [N-1:0]   sel_s,
    input logic [N-1:0]   sel_t,
    input logic [2*N-1:0] elem_state
);
    logic chk_prev;
    logic chk_qual;

    always_ff @(posedge clk) begin
        if (rst)
            chk_prev <= 1'b0;
        else
            chk_prev <= line_in;
    end

    always_comb begin
        case (edge_mode)
            2'd0:    chk_qual = line_in & ~chk_prev;
            2'd1:    chk_qual = ~line_in & chk_prev;
            default: chk_qual = line_in ^ chk_prev;
        endcase
    end

    // R1: exactly one 0-to-1 step going up the thermometer vector
    p_therm_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(sel_s & ~{sel_s[N-2:0], 1'b0}) == 1 && sel_s[N-1]);

    // R2: one-cold vector, zero exactly one above the thermometer step
    p_onecold_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(~sel_t) == 1 && sel_t[0]);

    p_cold_pos_r2: assert property (@(posedge clk) disable iff (rst)
        ~sel_t == {(sel_s[N-2:0] & ~{sel_s[N-3:0], 1'b0}), 1'b0});

    // R3: state word agrees with the two vectors
    for (genvar i = 0; i < N; i++) begin : g_st
        p_state_r3: assert property (@(posedge clk) disable iff (rst)
            elem_state[2*i +: 2] == (!sel_s[i] ? 2'b00 : (sel_t[i] ? 2'b01 : 2'b10)));
    end

    // R5 / R7: vectors move only after a qualifying transition
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !chk_qual |=> $stable(sel_s) && $stable(sel_t));

    // R9: state immediately after reset
    p_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_s == {N{1'b1}} && sel_t == ~(N'(2))));
endmodule

bind dl_ctrl_encoder dl_ctrl_encoder_chk #(.N(N), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .code_in    (code_in),
    .code_valid (code_valid),
    .edge_mode  (edge_mode),
    .line_in    (line_in),
    .sel_s      (sel_s),
    .sel_t      (sel_t),
    .elem_state (elem_state)
);

// File: tb/dl_ctrl_encoder_test.sv
module dl_ctrl_encoder_test;
    localparam int N        = 8;
    localparam int CW       = $clog2(N);
    localparam int CLK_PER  = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [CW-1:0]  code_in = '0;
    logic           code_valid = 1'b0;
    logic [1:0]     edge_mode = 2'd0;
    logic           line_in = 1'b0;
    logic [N-1:0]   sel_s;
    logic [N-1:0]   sel_t;
    logic [2*N-1:0] elem_state;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    dl_ctrl_encoder #(.N(N)) uut (
        .clk(clk), .rst(rst), .code_in(code_in), .code_valid(code_valid),
        .edge_mode(edge_mode), .line_in(line_in),
        .sel_s(sel_s), .sel_t(sel_t), .elem_state(elem_state)
    );

    always #(CLK_PER/2) clk = ~clk;

    // behavioural reference model
    int m_code = 0;
    int m_shadow = 0;
    bit m_pend = 0;
    bit m_prev = 0;

    always @(posedge clk) begin
        bit q;
        if (rst) begin
            m_code = 0; m_shadow = 0; m_pend = 0; m_prev = 0;
        end else begin
            case (edge_mode)
                2'd0:    q = line_in && !m_prev;
                2'd1:    q = !line_in && m_prev;
                default: q = line_in != m_prev;
            endcase
            if (q && m_pend) begin
                m_code = m_shadow;
                m_pend = 0;
            end
            if (code_valid) begin
                m_shadow = (int'(code_in) > N-2) ? N-2 : int'(code_in);
                m_pend = 1;
            end
            m_prev = line_in;
        end
    end

    function automatic logic [N-1:0] exp_s(int c);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (i >= c);
        return v;
    endfunction

    function automatic logic [N-1:0] exp_t(int c);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (i != c + 1);
        return v;
    endfunction

    function automatic logic [2*N-1:0] exp_st(int c);
        logic [2*N-1:0] v;
        for (int i = 0; i < N; i++) begin
            if (i < c)          v[2*i +: 2] = 2'b00;
            else if (i == c+1)  v[2*i +: 2] = 2'b10;
            else                v[2*i +: 2] = 2'b01;
        end
        return v;
    endfunction

    task automatic chk(string tag, logic [2*N-1:0] got, logic [2*N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1 model sel_s", {{N{1'b0}}, sel_s}, {{N{1'b0}}, exp_s(m_code)});
            chk("R2 model sel_t", {{N{1'b0}}, sel_t}, {{N{1'b0}}, exp_t(m_code)});
            chk("R3 model elem_state", elem_state, exp_st(m_code));
        end
    end

    task automatic cyc(bit v, int c, bit l);
        code_valid = v;
        code_in = CW'(c);
        line_in = l;
        @(negedge clk);
    endtask

    task automatic chk_vec(string tag, logic [N-1:0] es, logic [N-1:0] et);
        chk({tag, " S"}, {{N{1'b0}}, sel_s}, {{N{1'b0}}, es});
        chk({tag, " T"}, {{N{1'b0}}, sel_t}, {{N{1'b0}}, et});
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_vec("R9 reset", 8'hFF, 8'hFD);

        // rising mode, strobe then wait
        edge_mode = 2'd0;
        cyc(1, 3, 0);
        cyc(0, 0, 0);
        cyc(0, 0, 0);
        chk_vec("R5 held without edge", 8'hFF, 8'hFD);
        cyc(0, 0, 1);
        chk_vec("R7 applied on rise", 8'hF8, 8'hEF);
        chk("R3 state code 3", elem_state, 16'h5640);
        cyc(0, 0, 0);
        cyc(0, 0, 1);
        chk_vec("R5 consumed code not reapplied", 8'hF8, 8'hEF);

        // clamp
        cyc(1, 7, 1);
        cyc(0, 0, 0);
        chk_vec("R6 fall ignored in rise mode", 8'hF8, 8'hEF);
        cyc(0, 0, 1);
        chk_vec("R4 clamp to N-2", 8'hC0, 8'h7F);

        // falling mode
        edge_mode = 2'd1;
        cyc(1, 1, 1);
        cyc(0, 0, 0);
        chk_vec("R6 fall mode applies", 8'hFE, 8'hFB);
        cyc(1, 2, 0);
        cyc(0, 0, 1);
        chk_vec("R6 rise ignored in fall mode", 8'hFE, 8'hFB);
        cyc(0, 0, 0);
        chk_vec("R6 fall mode second", 8'hFC, 8'hF7);

        // either mode
        edge_mode = 2'd2;
        cyc(1, 5, 0);
        cyc(0, 0, 1);
        chk_vec("R6 any mode rise", 8'hE0, 8'hBF);
        cyc(1, 0, 1);
        cyc(0, 0, 0);
        chk_vec("R6 any mode fall code 0", 8'hFF, 8'hFD);

        // strobe coinciding with edge
        cyc(1, 4, 0);
        cyc(1, 2, 1);
        chk_vec("R8 older pending applied", 8'hF0, 8'hDF);
        cyc(0, 0, 0);
        chk_vec("R8 newer applied next edge", 8'hFC, 8'hF7);
        cyc(1, 6, 1);
        chk_vec("R8 nothing pending waits", 8'hFC, 8'hF7);
        cyc(0, 0, 0);
        chk_vec("R8 waiting code applied", 8'hC0, 8'h7F);

        // mid-run reset
        rst = 1'b1;
        cyc(0, 0, 0);
        rst = 1'b0;
        cyc(0, 0, 0);
        chk_vec("R9 reset mid-run", 8'hFF, 8'hFD);

        // pseudo-random traffic, checked by the model
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            edge_mode = lfsr[9:8];
            cyc(lfsr[0] & lfsr[5], int'(lfsr[4:2]), lfsr[7] ^ lfsr[1]);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PER * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule